// File: doc/BRIEF.md
# AAL1 Sequence Header Generator with Residual Time Stamp Insertion

This block builds the one-byte cell header for a single constant-bit-rate adaptation-layer channel. Each time the cell assembler asks for a header, the block returns a byte one cycle later. The byte holds a 3-bit sequence number, a single indication bit, a 3-bit CRC over those four bits and an even parity bit. The sequence number advances by one with every header and repeats every eight cells.

When time stamp insertion is enabled, the indication bit carries a 4-bit residual time stamp. The stamp is spread over the four odd-numbered cells of each eight-cell cycle, most significant bit first. An external clock-difference circuit supplies the stamp with a valid flag. The block samples it once per cycle, on the header with sequence number 0, and pulses an acknowledge in that cycle. If no fresh stamp is offered at that point, the previous stamp is sent again and the header is marked as an underrun. Payload assembly, cell scheduling and pointer insertion for structured data belong to other blocks.

Top module: `aal1_hdr_gen`

## Requirements
- R1: While reset is asserted and at the first clock after it, `hdr_valid` is 0. The first header after reset carries sequence number 0, and the stored time stamp resets to 0.
- R2: A header request sampled at a rising edge gives `hdr_valid`=1 with the new byte after that same edge. A cycle without a request gives `hdr_valid`=0 and leaves the sequence number unchanged.
- R3: The sequence number goes up by one for each header issued and wraps from 7 to 0.
- R4: The header byte is laid out as follows. Bit 7 is the indication bit and bits 6:4 are the sequence number. Bits 3:1 are the remainder of (bits 7:4 · x^3) divided by x^3+x+1, with bit 7 as the highest data bit. Bit 0 makes the count of ones in the byte even.
- R5: With `srts_en`=0, the indication bit is 0 in every header, `hdr_underrun` stays 0, `ts_take` stays 0 and the stored time stamp is not changed.
- R6: Headers with an even sequence number (0, 2, 4, 6) always have an indication bit of 0.
- R7: With `srts_en`=1, the indication bit of sequence numbers 1, 3, 5 and 7 is stored stamp bit 3, 2, 1 and 0 respectively.
- R8: The stamp is stored only on a request for sequence number 0 with `srts_en`=1 and `ts_valid`=1, and `ts_take` is 1 in exactly that cycle. Stamps offered in the middle of a cycle are ignored.
- R9: On a request for sequence number 0 with `srts_en`=1 and `ts_valid`=0, the previous stamp is kept for the new cycle and that header has `hdr_underrun`=1. Every other header has `hdr_underrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| srts_en | input | 1 | Enables time stamp transport in the indication bit |
| ts_code | input | 4 | Residual time stamp offered by the external circuit |
| ts_valid | input | 1 | `ts_code` holds a fresh stamp |
| ts_take | output | 1 | Stamp consumed this cycle (combinational) |
| hdr_req | input | 1 | Request for the next header |
| hdr_valid | output | 1 | `hdr_byte` holds a new header |
| hdr_byte | output | 8 | Header byte |
| hdr_underrun | output | 1 | This header reused the previous stamp |

## Verification
The assertions assume that `srts_en` changes only between eight-cell cycles and that `hdr_req` is a clean single-bit strobe. They also assume `ts_code` is stable while `ts_valid` is high in the sampling cycle. The stimulus changes every input at the falling edge. It toggles the enable only at a point where the next header has sequence number 0. Stamps are offered both at and away from the sampling point, and stamps with alternating bit patterns show the bit order.

// File: rtl/aal1_hdr_pkg.sv
package aal1_hdr_pkg;

   localparam int SN_W   = 3;
   localparam int CRC_W  = 3;
   localparam int HDR_W  = 8;
   localparam int TS_W   = 4;
   localparam logic [CRC_W:0] CRC_POLY = 4'b1011;   // x^3 + x + 1

   typedef struct packed {
      logic             ind;
      logic [SN_W-1:0]  sn;
      logic [CRC_W-1:0] crc;
      logic             par;
   } hdr_t;

   // Long division of {data, zeros} by the generator.
   function automatic logic [CRC_W-1:0] crc3_div(input logic [SN_W:0] data);
      logic [SN_W+CRC_W:0] w;
      w = {data, {CRC_W{1'b0}}};
      for (int i = SN_W + CRC_W; i >= CRC_W; i--) begin
         if (w[i]) w[i -: CRC_W+1] = w[i -: CRC_W+1] ^ CRC_POLY;
      end
      return w[CRC_W-1:0];
   endfunction

endpackage

// File: rtl/aal1_seq_ctr.sv
module aal1_seq_ctr #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + ONE;   // natural wrap at 2**W
   end

   assign count = cnt_q;

   // R3: one step per header, modulo 2**W
   a_r3_seq_step : assert property (@(posedge clk) disable iff (!rst_n)
      step |=> cnt_q == $past(cnt_q) + ONE);

   // R2: count holds without a request
   a_r2_seq_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt_q));

endmodule

// File: rtl/aal1_ts_store.sv
module aal1_ts_store #(
   parameter int SN_W = 3,
   parameter int TS_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            req,
   input  logic [SN_W-1:0] sn,
   input  logic [TS_W-1:0] ts_code,
   input  logic            ts_valid,
   output logic            ts_take,
   output logic            ind_bit,
   output logic            underrun
);
   localparam int SLOTS = 2 ** SN_W;

   logic [TS_W-1:0] code_q;
   logic [TS_W-1:0] slot_hit;
   logic            cycle_start;

   assign cycle_start = req && (sn == '0) && en;
   assign ts_take     = cycle_start && ts_valid;
   assign underrun    = cycle_start && !ts_valid;

   always_ff @(posedge clk) begin
      if (!rst_n)       code_q <= '0;
      else if (ts_take) code_q <= ts_code;
   end

   // Odd slot 2k+1 carries stamp bit TS_W-1-k (first odd slot gets the MSB).
   for (genvar k = 0; k < TS_W; k++) begin : g_slot
      localparam logic [SN_W-1:0] ODD_SN = SN_W'(2 * k + 1);
      assign slot_hit[k] = (sn == ODD_SN) && code_q[TS_W-1-k];
   end

   assign ind_bit = en && (|slot_hit);

   if (2 * TS_W != SLOTS) begin : g_bad_ts
      $error("aal1_ts_store: stamp width must be half the cycle length");
   end

   // R8: stored stamp changes only at a cycle start
   a_r8_code_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_start |=> $stable(code_q));

   // R6: even slots never carry a stamp bit
   a_r6_even_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !sn[0] |-> !ind_bit);

   // R5: disabled channel is silent
   a_r5_off_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !ind_bit && !ts_take && !underrun);

   // R9: take and underrun are exclusive
   a_r9_take_xor_under : assert property (@(posedge clk) disable iff (!rst_n)
      !(ts_take && underrun));

endmodule

// File: rtl/aal1_hdr_pack.sv
module aal1_hdr_pack
   import aal1_hdr_pkg::*;
#(
   parameter int CRC_STYLE = 0   // 0: division loop, 1: flat XOR equations
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             ind_bit,
   input  logic [SN_W-1:0]  sn,
   input  logic             und_in,
   output logic             hdr_valid,
   output logic [HDR_W-1:0] hdr_byte,
   output logic             hdr_underrun
);
   logic [SN_W:0]    crc_in;
   logic [CRC_W-1:0] crc;
   hdr_t             hdr_d;

   assign crc_in = {ind_bit, sn};

   if (CRC_STYLE == 0) begin : g_crc_div
      assign crc = crc3_div(crc_in);
   end else if (CRC_STYLE == 1) begin : g_crc_xor
      // x^3=x+1, x^4=x^2+x, x^5=x^2+x+1, x^6=x^2+1
      assign crc[0] = crc_in[0] ^ crc_in[2] ^ crc_in[3];
      assign crc[1] = crc_in[0] ^ crc_in[1] ^ crc_in[2];
      assign crc[2] = crc_in[1] ^ crc_in[2] ^ crc_in[3];
   end else begin : g_bad_style
      $error("aal1_hdr_pack: CRC_STYLE must be 0 or 1");
   end

   always_comb begin
      hdr_d.ind = ind_bit;
      hdr_d.sn  = sn;
      hdr_d.crc = crc;
      hdr_d.par = ^{ind_bit, sn, crc};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr_valid    <= 1'b0;
         hdr_byte     <= '0;
         hdr_underrun <= 1'b0;
      end else begin
         hdr_valid    <= req;
         hdr_underrun <= req && und_in;
         if (req) hdr_byte <= hdr_d;
      end
   end

   // R4: complete byte has even weight
   a_r4_even_parity : assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> (^hdr_byte) == 1'b0);

   // R2: header follows request by one edge
   a_r2_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
      req |=> hdr_valid);

   a_r2_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !hdr_valid);

endmodule

// File: rtl/aal1_hdr_gen.sv
module aal1_hdr_gen
   import aal1_hdr_pkg::*;
#(
   parameter int CRC_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srts_en,
   input  logic [TS_W-1:0]  ts_code,
   input  logic             ts_valid,
   output logic             ts_take,
   input  logic             hdr_req,
   output logic             hdr_valid,
   output logic [HDR_W-1:0] hdr_byte,
   output logic             hdr_underrun
);
   logic [SN_W-1:0] sn;
   logic            ind_bit;
   logic            und_now;

   if (HDR_W != 1 + SN_W + CRC_W + 1) begin : g_bad_hdr
      $error("aal1_hdr_gen: header fields do not fill the byte");
   end

   aal1_seq_ctr #(.W(SN_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (hdr_req),
      .count (sn)
   );

   aal1_ts_store #(.SN_W(SN_W), .TS_W(TS_W)) u_ts (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (srts_en),
      .req      (hdr_req),
      .sn       (sn),
      .ts_code  (ts_code),
      .ts_valid (ts_valid),
      .ts_take  (ts_take),
      .ind_bit  (ind_bit),
      .underrun (und_now)
   );

   aal1_hdr_pack #(.CRC_STYLE(CRC_STYLE)) u_pack (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (hdr_req),
      .ind_bit      (ind_bit),
      .sn           (sn),
      .und_in       (und_now),
      .hdr_valid    (hdr_valid),
      .hdr_byte     (hdr_byte),
      .hdr_underrun (hdr_underrun)
   );

   // R9: underrun only flags a cycle-start header
   a_r9_under_on_zero : assert property (@(posedge clk) disable iff (!rst_n)
      hdr_underrun |-> hdr_valid && (hdr_byte[6:4] == 3'd0));

   // R8: a stamp is consumed only on a cycle-start request
   a_r8_take_on_req : assert property (@(posedge clk) disable iff (!rst_n)
      ts_take |-> hdr_req && ts_valid && srts_en);

endmodule

// File: tb/aal1_hdr_gen_bench.sv
module aal1_hdr_gen_bench;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       srts_en;
   logic [3:0] ts_code;
   logic       ts_valid;
   logic       ts_take;
   logic       hdr_req;
   logic       hdr_valid;
   logic [7:0] hdr_byte;
   logic       hdr_underrun;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   aal1_hdr_gen u_aal1_hdr_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .srts_en      (srts_en),
      .ts_code      (ts_code),
      .ts_valid     (ts_valid),
      .ts_take      (ts_take),
      .hdr_req      (hdr_req),
      .hdr_valid    (hdr_valid),
      .hdr_byte     (hdr_byte),
      .hdr_underrun (hdr_underrun)
   );

   // {en, ts_valid, code[3:0], exp_sn[2:0], exp_ind, exp_under}
   localparam int NV = 16;
   localparam logic [10:0] VEC [NV] = '{
      {1'b1, 1'b1, 4'hA, 3'd0, 1'b0, 1'b0},
      {1'b1, 1'b1, 4'h5, 3'd1, 1'b1, 1'b0},
      {1'b1, 1'b0, 4'h5, 3'd2, 1'b0, 1'b0},
      {1'b1, 1'b1, 4'h5, 3'd3, 1'b0, 1'b0},
      {1'b1, 1'b0, 4'h0, 3'd4, 1'b0, 1'b0},
      {1'b1, 1'b1, 4'hF, 3'd5, 1'b1, 1'b0},
      {1'b1, 1'b0, 4'h0, 3'd6, 1'b0, 1'b0},
      {1'b1, 1'b1, 4'h0, 3'd7, 1'b0, 1'b0},
      {1'b1, 1'b0, 4'h3, 3'd0, 1'b0, 1'b1},
      {1'b1, 1'b0, 4'h3, 3'd1, 1'b1, 1'b0},
      {1'b1, 1'b0, 4'h0, 3'd2, 1'b0, 1'b0},
      {1'b1, 1'b0, 4'h0, 3'd3, 1'b0, 1'b0},
      {1'b1, 1'b0, 4'h0, 3'd4, 1'b0, 1'b0},
      {1'b1, 1'b0, 4'h0, 3'd5, 1'b1, 1'b0},
      {1'b1, 1'b0, 4'h0, 3'd6, 1'b0, 1'b0},
      {1'b1, 1'b0, 4'h0, 3'd7, 1'b0, 1'b0}
   };

   // Bench's own CRC: bit-serial LFSR for x^3+x+1, MSB first.
   function automatic logic [2:0] tb_crc(input logic [3:0] d);
      logic [2:0] r = 3'b000;
      for (int i = 3; i >= 0; i--) begin
         logic fb;
         fb = d[i] ^ r[2];
         r  = {r[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
      end
      return r;
   endfunction

   function automatic logic [7:0] tb_hdr(input logic ind, input logic [2:0] sn);
      logic [6:0] top7;
      top7 = {ind, sn, tb_crc({ind, sn})};
      return {top7, ^top7};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One request: drive at falling edge, check take before the edge,
   // check header at the next falling edge.
   task automatic do_req(input logic en, input logic tv, input logic [3:0] code,
                         input logic [2:0] e_sn, input logic e_ind,
                         input logic e_und, input string tag);
      srts_en  = en;
      ts_valid = tv;
      ts_code  = code;
      hdr_req  = 1'b1;
      #1;
      check("R8", {tag, " ts_take"}, 8'(ts_take), 8'(en && tv && e_sn == 3'd0));
      @(posedge clk);
      @(negedge clk);
      hdr_req  = 1'b0;
      ts_valid = 1'b0;
      check("R2", {tag, " hdr_valid"}, 8'(hdr_valid), 8'd1);
      check("R4", {tag, " hdr_byte"}, hdr_byte, tb_hdr(e_ind, e_sn));
      check("R9", {tag, " hdr_underrun"}, 8'(hdr_underrun), 8'(e_und));
   endtask

   // Full cycle using a stored stamp model (R7 bit order).
   task automatic run_cycle(input logic en, input logic tv0, input logic [3:0] code0,
                            input logic [3:0] stored, input logic e_und0,
                            input string tag);
      for (int s = 0; s < 8; s++) begin
         logic ind;
         ind = en && s[0] && stored[3 - (s >> 1)];
         if (s == 0) do_req(en, tv0, code0, 3'(s), 1'b0, e_und0, tag);
         else        do_req(en, 1'b0, 4'h0, 3'(s), ind, 1'b0, tag);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; srts_en = 1'b0; ts_code = 4'h0; ts_valid = 1'b0; hdr_req = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "valid in reset", 8'(hdr_valid), 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "valid after reset", 8'(hdr_valid), 8'd0);

      // Table: two cycles, fresh stamp then underrun reuse (R3, R6, R7, R8, R9)
      for (int i = 0; i < NV; i++) begin
         logic [10:0] v;
         v = VEC[i];
         do_req(v[10], v[9], v[8:5], v[4:2], v[1], v[0], $sformatf("R3 vec%0d", i));
      end

      // R2: idle cycles give no header and hold the count
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R2", "idle hdr_valid", 8'(hdr_valid), 8'd0);
      end

      // R7: stamp 0101 shows the reversed bit placement
      run_cycle(1'b1, 1'b1, 4'h5, 4'h5, 1'b0, "R7 code5");
      // R5: disabled, no stamp offered; indication stays zero, no underrun
      run_cycle(1'b0, 1'b0, 4'hC, 4'h5, 1'b0, "R5 off");
      // R9: enabled again without a stamp; stamp 5 still stored
      run_cycle(1'b1, 1'b0, 4'hC, 4'h5, 1'b1, "R9 reuse");

      // R1: reset in mid-cycle restarts numbering and clears the stamp
      do_req(1'b1, 1'b1, 4'hF, 3'd0, 1'b0, 1'b0, "R1 pre");
      do_req(1'b1, 1'b0, 4'h0, 3'd1, 1'b1, 1'b0, "R1 pre");
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R1", "valid in mid reset", 8'(hdr_valid), 8'd0);
      rst_n = 1'b1;
      run_cycle(1'b1, 1'b0, 4'h0, 4'h0, 1'b1, "R1 post");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule